// File: doc/BRIEF.md
# Three-Counter Match-Compare Timer

This block is a timer peripheral on a processor's register bus. It has several counters (three by default), each with several match comparators (three by default). Every comparator owns a sticky status bit and a mask bit, and one interrupt line collects the unmasked status bits of all counters. Each counter either runs freely, counting past its match values and wrapping, or runs periodically, returning to a loadable start value once its first comparator matches.

The counters advance on a slow timer clock that is not related to the bus clock. Software cannot sample a running count directly. It writes a capture request for one counter, waits a few bus cycles, and reads a snapshot that the two clock domains handed over through a toggle handshake. Until the handshake completes, the capture location still returns the previous snapshot. Run control crosses into the timer domain through a synchroniser. Match, start value and mode settings are treated as static, and software changes them only while the counter is stopped.

Register map (word addresses): address 0 holds the run bits. Counter i owns a 16-word block at 16*(i+1), laid out as follows:

| Offset | Contents |
|---|---|
| +k | match value of comparator k |
| +8 | start value |
| +9 | mode |
| +10 | status |
| +11 | mask |
| +12 | capture |

Top module: `mctimer`

## Requirements
- R1: After reset every register reads 0, all counters are stopped, all captures read 0 and `irq` is low.
- R2: Bit i of the run register (address 0) starts counter i when set and stops it when clear. A stopped counter keeps its count unchanged, and a counter that was never started reads 0.
- R3: When a counter goes from stopped to running, it restarts from the value held at its start-value offset (+8).
- R4: In free-running mode (mode offset +9, bit 0 = 0) a counter increments once per timer tick. It counts past every match value and wraps modulo 2^32.
- R5: In periodic mode (mode bit 0 = 1), a counter that equals the match value of comparator 0 loads its start value on the next tick. A running periodic counter therefore always lies between the start value and match 0, both included.
- R6: Status bit k (offset +10) becomes 1 when the running count equals match k. A set arriving in the same bus cycle as a clear of that bit wins, so no match is lost.
- R7: Writing the status offset clears the bits written as 1. Bits written as 0 are left unchanged.
- R8: `irq` is high exactly when some status bit of some counter has its mask bit (offset +11) set. With all mask bits 0, `irq` stays low whatever the status bits hold.
- R9: Writing 1 in bit 0 of the capture offset (+12) requests a snapshot of the count. A read just after the request still returns the previous snapshot. After the handshake, the read returns a count taken after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| tick_clk | input | 1 | Slow timer clock that advances the counters |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_addr | input | AW (8) | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of bus_clk |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| irq | output | 1 | OR of all unmasked status bits |

## Verification
Counter 0 is tried in free-running mode with large match values, with a start value near the top of the range so it wraps, and across stop and restart with random start values. These cases separate a count that freezes from one that drifts and a restart from the start value from a resume. Counter 1 runs periodically and is sampled at random times, so any snapshot outside the start-to-match window exposes a missing reload. Counter 2 runs freely from a random start with random gaps between captures, which tells a real, monotonic count from stale or reordered snapshots. Status and mask bits are driven through clears of single bits and of all bits and through mask patterns, while counter 1 keeps matching under repeated clears, which shows whether a match that coincides with a clear survives.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
   // Per-counter register block: 16 words, comparator k sits at offset k.
   localparam int unsigned BLK_LG = 4;
   localparam logic [3:0] OFS_START = 4'd8;
   localparam logic [3:0] OFS_MODE  = 4'd9;
   localparam logic [3:0] OFS_STAT  = 4'd10;
   localparam logic [3:0] OFS_MASK  = 4'd11;
   localparam logic [3:0] OFS_SNAP  = 4'd12;

   typedef enum logic {
      MODE_FREE     = 1'b0,
      MODE_PERIODIC = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/mct_sync.sv
`timescale 1ns/1ps
module mct_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mct_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
module mct_counter #(
   parameter int unsigned CW   = 32,
   parameter int unsigned NCMP = 3,
   parameter int unsigned SYNC = 2
) (
   input  logic                     tclk,
   input  logic                     rst_n,
   input  logic                     run_a,
   input  logic                     periodic,
   input  logic [CW-1:0]            start_val,
   input  logic [NCMP-1:0][CW-1:0]  match,
   input  logic                     req_a,
   output logic [CW-1:0]            snap_q,
   output logic                     ack_q,
   output logic [NCMP-1:0]          evt_q
);
   logic [1:0]      sync_q;
   logic            run_s, req_s, run_d, req_d;
   logic [CW-1:0]   count_q, count_nx;
   logic [NCMP-1:0] hit;

   mct_sync #(.W(2), .STAGES(SYNC)) u_sync (
      .clk   (tclk),
      .rst_n (rst_n),
      .d     ({run_a, req_a}),
      .q     (sync_q)
   );
   assign run_s = sync_q[1];
   assign req_s = sync_q[0];

   generate
      for (genvar k = 0; k < NCMP; k++) begin : g_cmp
         assign hit[k] = run_s & run_d & (count_q == match[k]);
      end
   endgenerate

   always_comb begin
      count_nx = count_q;
      if (run_s) begin
         if (!run_d)                         count_nx = start_val;
         else if (periodic && hit[0])        count_nx = start_val;
         else                                count_nx = count_q + 1'b1;
      end
   end

   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
         run_d   <= 1'b0;
         req_d   <= 1'b0;
         count_q <= '0;
         snap_q  <= '0;
         ack_q   <= 1'b0;
         evt_q   <= '0;
      end else begin
         run_d   <= run_s;
         req_d   <= req_s;
         count_q <= count_nx;
         evt_q   <= evt_q ^ hit;
         if (req_s != req_d) begin
            snap_q <= count_q;
            ack_q  <= ~ack_q;
         end
      end
   end
endmodule

// File: rtl/mct_chan_regs.sv
`timescale 1ns/1ps
module mct_chan_regs
   import mct_pkg::*;
#(
   parameter int unsigned DW   = 32,
   parameter int unsigned CW   = 32,
   parameter int unsigned NCMP = 3,
   parameter int unsigned SYNC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [3:0]               ofs,
   input  logic [DW-1:0]            wdata,
   output logic [DW-1:0]            rdata,
   input  logic [NCMP-1:0]          evt_a,
   input  logic                     ack_a,
   input  logic [CW-1:0]            snap_src,
   output logic [NCMP-1:0][CW-1:0]  match_q,
   output logic [CW-1:0]            start_q,
   output logic                     periodic_q,
   output logic                     req_q,
   output logic [NCMP-1:0]          stat_q,
   output logic [NCMP-1:0]          mask_q,
   output logic [NCMP-1:0]          set_p,
   output logic [NCMP-1:0]          clr_m
);
   generate
      if (NCMP > 8) begin : g_bad_ncmp
         $error("mct_chan_regs: at most 8 comparators fit the block");
      end
      if (CW > DW) begin : g_bad_cw
         $error("mct_chan_regs: counter wider than bus");
      end
   endgenerate

   logic [NCMP-1:0] evt_s, evt_d;
   logic            ack_s, ack_d;
   logic [CW-1:0]   snap_q;

   mct_sync #(.W(NCMP), .STAGES(SYNC)) u_evt_sync (
      .clk(clk), .rst_n(rst_n), .d(evt_a), .q(evt_s)
   );
   mct_sync #(.W(1), .STAGES(SYNC)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_a), .q(ack_s)
   );

   assign set_p = evt_s ^ evt_d;
   assign clr_m = (wr_en && ofs == OFS_STAT) ? wdata[NCMP-1:0] : '0;

   generate
      for (genvar k = 0; k < NCMP; k++) begin : g_match
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          match_q[k] <= '0;
            else if (wr_en && ofs == 4'(k))      match_q[k] <= wdata[CW-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q    <= '0;
         periodic_q <= MODE_FREE;
         req_q      <= 1'b0;
         stat_q     <= '0;
         mask_q     <= '0;
         evt_d      <= '0;
         ack_d      <= 1'b0;
         snap_q     <= '0;
      end else begin
         evt_d  <= evt_s;
         ack_d  <= ack_s;
         stat_q <= (stat_q & ~clr_m) | set_p;
         if (ack_s != ack_d) snap_q <= snap_src;
         if (wr_en) begin
            unique case (ofs)
               OFS_START: start_q    <= wdata[CW-1:0];
               OFS_MODE:  periodic_q <= wdata[0];
               OFS_MASK:  mask_q     <= wdata[NCMP-1:0];
               OFS_SNAP:  if (wdata[0]) req_q <= ~req_q;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NCMP; k++) begin
         if (ofs == 4'(k)) rdata[CW-1:0] = match_q[k];
      end
      case (ofs)
         OFS_START: rdata[CW-1:0]   = start_q;
         OFS_MODE:  rdata[0]        = periodic_q;
         OFS_STAT:  rdata[NCMP-1:0] = stat_q;
         OFS_MASK:  rdata[NCMP-1:0] = mask_q;
         OFS_SNAP:  rdata[CW-1:0]   = snap_q;
         default:   ;
      endcase
   end
endmodule

// File: rtl/mctimer.sv
`timescale 1ns/1ps
module mctimer
   import mct_pkg::*;
#(
   parameter int unsigned NCNT = 3,
   parameter int unsigned NCMP = 3,
   parameter int unsigned CW   = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 8,
   parameter int unsigned SYNC = 2
) (
   input  logic          bus_clk,
   input  logic          tick_clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   localparam int unsigned SEL_W = AW - BLK_LG;

   generate
      if (((NCNT + 1) << BLK_LG) > (1 << AW)) begin : g_bad_aw
         $error("mctimer: address space too small for NCNT blocks");
      end
      if (NCNT > DW) begin : g_bad_ncnt
         $error("mctimer: run register wider than bus");
      end
   endgenerate

   logic [NCNT-1:0]                      run_q;
   logic [SEL_W-1:0]                     blk_sel;
   logic [NCNT-1:0][DW-1:0]              ch_rdata;
   logic [NCNT-1:0][NCMP-1:0]            ch_stat, ch_mask, ch_set, ch_clr, ch_evt;
   logic [NCNT-1:0]                      ch_req, ch_ack, ch_periodic;
   logic [NCNT-1:0][CW-1:0]              ch_start, ch_snap;
   logic [NCNT-1:0][NCMP-1:0][CW-1:0]    ch_match;

   assign blk_sel = bus_addr[AW-1:BLK_LG];

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                           run_q <= '0;
      else if (bus_wr && bus_addr == '0)    run_q <= bus_wdata[NCNT-1:0];
   end

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_ch
         logic wr_i;
         assign wr_i = bus_wr && (blk_sel == SEL_W'(i + 1));

         mct_chan_regs #(.DW(DW), .CW(CW), .NCMP(NCMP), .SYNC(SYNC)) u_regs (
            .clk        (bus_clk),
            .rst_n      (rst_n),
            .wr_en      (wr_i),
            .ofs        (bus_addr[BLK_LG-1:0]),
            .wdata      (bus_wdata),
            .rdata      (ch_rdata[i]),
            .evt_a      (ch_evt[i]),
            .ack_a      (ch_ack[i]),
            .snap_src   (ch_snap[i]),
            .match_q    (ch_match[i]),
            .start_q    (ch_start[i]),
            .periodic_q (ch_periodic[i]),
            .req_q      (ch_req[i]),
            .stat_q     (ch_stat[i]),
            .mask_q     (ch_mask[i]),
            .set_p      (ch_set[i]),
            .clr_m      (ch_clr[i])
         );

         mct_counter #(.CW(CW), .NCMP(NCMP), .SYNC(SYNC)) u_cnt (
            .tclk      (tick_clk),
            .rst_n     (rst_n),
            .run_a     (run_q[i]),
            .periodic  (ch_periodic[i]),
            .start_val (ch_start[i]),
            .match     (ch_match[i]),
            .req_a     (ch_req[i]),
            .snap_q    (ch_snap[i]),
            .ack_q     (ch_ack[i]),
            .evt_q     (ch_evt[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (blk_sel == '0) begin
         if (bus_addr[BLK_LG-1:0] == '0) bus_rdata[NCNT-1:0] = run_q;
      end else begin
         for (int i = 0; i < NCNT; i++) begin
            if (blk_sel == SEL_W'(i + 1)) bus_rdata = ch_rdata[i];
         end
      end
   end

   assign irq = |(ch_stat & ch_mask);
endmodule

// File: rtl/mctimer_chk.sv
`timescale 1ns/1ps
module mctimer_chk #(
   parameter int unsigned NCNT = 3,
   parameter int unsigned NCMP = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       irq,
   input logic [NCNT-1:0][NCMP-1:0]  stat,
   input logic [NCNT-1:0][NCMP-1:0]  mask,
   input logic [NCNT-1:0][NCMP-1:0]  set_p,
   input logic [NCNT-1:0][NCMP-1:0]  clr_m
);
   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_i
         for (genvar k = 0; k < NCMP; k++) begin : g_k
            // R6
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
               set_p[i][k] |=> stat[i][k]);
            // R7
            clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_m[i][k] && !set_p[i][k]) |=> !stat[i][k]);
            // R7
            status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (stat[i][k] && !clr_m[i][k]) |=> stat[i][k]);
         end
      end
   endgenerate

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);
endmodule

bind mctimer mctimer_chk #(.NCNT(NCNT), .NCMP(NCMP)) u_chk (
   .clk   (bus_clk),
   .rst_n (rst_n),
   .irq   (irq),
   .stat  (ch_stat),
   .mask  (ch_mask),
   .set_p (ch_set),
   .clr_m (ch_clr)
);

// File: tb/mctimer_bench.sv
`timescale 1ns/1ps
module mctimer_bench;
   logic        bus_clk = 1'b0, tick_clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 bus_clk = ~bus_clk;
   always #18.5 tick_clk = ~tick_clk;

   mctimer u_mctimer (
      .bus_clk(bus_clk), .tick_clk(tick_clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [7:0] blk(input int ch, input int ofs);
      return 8'((ch + 1) * 16 + ofs);
   endfunction

   function automatic bit in_win(input logic [31:0] v, lo, hi);
      return (v >= lo) && (v <= hi);
   endfunction

   function automatic bit exp_irq(input logic [2:0] st, input logic [2:0] mk);
      return |(st & mk);
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge bus_clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic snap(input int ch, output logic [31:0] d);
      wr(blk(ch, 12), 32'h1);
      repeat (40) @(negedge bus_clk);
      rd(blk(ch, 12), d);
   endtask

   initial begin
      int unsigned seed;
      logic [31:0] v, v1, v2, p;
      seed = $urandom(32'd2718);
      repeat (5) @(negedge bus_clk);
      rst_n = 1'b1;
      repeat (5) @(negedge bus_clk);

      // R1: reset state
      rd(8'h00, v); check(v == 0, "R1 run reg", v, 0);
      for (int ch = 0; ch < 3; ch++) begin
         for (int o = 0; o < 13; o++) begin
            if (o < 3 || o >= 8) begin
               rd(blk(ch, o), v); check(v == 0, "R1 reg", v, 0);
            end
         end
      end
      check(irq == 1'b0, "R1 irq", 32'(irq), 0);

      // R9 / R2: counter 0 free-running
      for (int k = 0; k < 3; k++) wr(blk(0, k), 32'hFFFF_0000);
      wr(8'h00, 32'h1);
      repeat (100) @(negedge bus_clk);
      snap(0, v1);
      check(v1 != 0, "R9 first snapshot", v1, 1);
      wr(blk(0, 12), 32'h1);
      rd(blk(0, 12), v);
      check(v == v1, "R9 previous snapshot held", v, v1);
      repeat (40) @(negedge bus_clk);
      rd(blk(0, 12), v2);
      check(v2 > v1, "R9 new snapshot later", v2, v1 + 1);

      // R2: stopped counter freezes
      wr(8'h00, 32'h0);
      repeat (40) @(negedge bus_clk);
      snap(0, v1);
      repeat (100) @(negedge bus_clk);
      snap(0, v2);
      check(v2 == v1, "R2 frozen count", v2, v1);

      // R3: restart from start value, random values
      for (int it = 0; it < 3; it++) begin
         p = $urandom() & 32'h0FFF_FFFF;
         wr(blk(0, 8), p);
         wr(8'h00, 32'h1);
         repeat (60) @(negedge bus_clk);
         wr(8'h00, 32'h0);
         repeat (40) @(negedge bus_clk);
         snap(0, v);
         check(in_win(v, p, p + 40), "R3 restart from start value", v, p);
      end

      // R4 / R6: wrap past the top and count past matches
      wr(blk(0, 10), 32'h7);
      rd(blk(0, 10), v); check(v == 0, "R7 clear all", v, 0);
      wr(blk(0, 8), 32'hFFFF_FFF8);
      wr(blk(0, 0), 32'hFFFF_FFFC);
      wr(blk(0, 1), 32'h0000_0005);
      wr(blk(0, 2), 32'h7FFF_FFFF);
      wr(8'h00, 32'h1);
      repeat (200) @(negedge bus_clk);
      wr(8'h00, 32'h0);
      repeat (40) @(negedge bus_clk);
      snap(0, v);
      check(v > 32'h5 && v < 32'h40, "R4 wrapped count", v, 32'h10);
      rd(blk(0, 10), v); check(v == 32'h3, "R6 status after matches", v, 3);

      // R8 / R7: masking and write-one-to-clear
      check(irq == exp_irq(3'b011, 3'b000), "R8 masked irq", 32'(irq), 0);
      wr(blk(0, 11), 32'h2);
      check(irq == exp_irq(3'b011, 3'b010), "R8 unmasked irq", 32'(irq), 1);
      wr(blk(0, 10), 32'h0);
      rd(blk(0, 10), v); check(v == 32'h3, "R7 zero write no effect", v, 3);
      wr(blk(0, 10), 32'h1);
      rd(blk(0, 10), v); check(v == 32'h2, "R7 clear bit0", v, 2);
      check(irq == exp_irq(3'b010, 3'b010), "R8 irq remains", 32'(irq), 1);
      wr(blk(0, 10), 32'h2);
      @(negedge bus_clk);
      check(irq == exp_irq(3'b000, 3'b010), "R8 irq drops", 32'(irq), 0);

      // R5: counter 1 periodic between 100 and 130
      wr(blk(1, 8), 32'd100);
      wr(blk(1, 0), 32'd130);
      wr(blk(1, 1), 32'd115);
      wr(blk(1, 2), 32'h1000);
      wr(blk(1, 9), 32'h1);
      wr(blk(1, 11), 32'h1);
      wr(8'h00, 32'h2);
      repeat (40) @(negedge bus_clk);
      for (int it = 0; it < 8; it++) begin
         repeat (20 + ($urandom() % 100)) @(negedge bus_clk);
         snap(1, v);
         check(in_win(v, 100, 130), "R5 periodic window", v, 100);
      end
      rd(blk(1, 10), v); check(v == 32'h3, "R6 periodic status", v, 3);
      check(irq == 1'b1, "R8 irq from counter 1", 32'(irq), 1);

      // R2: counter 2 never started
      snap(2, v); check(v == 0, "R2 idle counter", v, 0);

      // R4 / R9: counter 2 random free run, monotonic snapshots
      p = $urandom() & 32'h7FFF_FFFF;
      wr(blk(2, 8), p);
      wr(8'h00, 32'h6);
      repeat (40) @(negedge bus_clk);
      for (int it = 0; it < 5; it++) begin
         int unsigned w;
         w = 40 + ($urandom() % 160);
         snap(2, v1);
         repeat (w) @(negedge bus_clk);
         snap(2, v2);
         v = v2 - v1;
         check(in_win(v, 1, 32'((w + 50) / 6 + 2)), "R4 count advance", v, 32'((w + 42) / 7));
      end

      // R6: repeated clears while counter 1 keeps matching
      for (int it = 0; it < 20; it++) begin
         wr(blk(1, 10), 32'h1);
         repeat (1 + ($urandom() % 10)) @(negedge bus_clk);
      end
      repeat (300) @(negedge bus_clk);
      rd(blk(1, 10), v); check(v[0] == 1'b1, "R6 match after clears", v, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(500_000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule